// File: doc/BRIEF.md
# Speculative Store Buffer with Commit and Abort

The block holds every store issued by one speculative context, either a speculatively forked thread or a software transaction, so that the work can later be written to memory or dropped. A `start_i` pulse opens a window. The mode select and the full policy are latched on that pulse. Inside the window, stores from the owning context are captured in order. Loads from the owning context are served from the youngest captured store to the same address, and any other load goes to memory.

In thread mode, addresses that the owning (more speculative) context fetched from memory are recorded in a read set. A store from the less speculative context to one of those addresses is a dependence violation. The block then empties both the store buffer and the read set and raises a restart request, and the window stays open while the thread re-executes. In transaction mode no hazard check is made and the block only buffers. An abort in transaction mode raises a redirect to the handler address latched at start, together with a request to restore the saved register state.

A commit releases the captured stores to a drain port, one per cycle, oldest first, and `drain_busy_o` stays high until the last one has gone out. When the store buffer, or in thread mode the read set, is full, the latched policy commits or aborts the window by itself in that same cycle.

Top module: `spec_store_buffer`

## Requirements
- R1: While a window is open, no store appears on the drain port. Captured stores reach memory only after a commit.
- R2: On a commit (explicit or by policy), the captured stores leave on the drain port starting in the next cycle. They go one per cycle in capture order. `drain_busy_o` is high exactly while stores remain. A commit with nothing captured drains nothing.
- R3: An abort (explicit or by policy) discards every captured store and the read set. No drain follows. In thread mode it pulses `restart_o` in the next cycle.
- R4: A load from the owning context (`req_older_i`=0) in an open window whose address matches a captured store gives `fwd_hit_o`=1 in the same cycle. `fwd_data_o` is the data of the most recent such store.
- R5: `mem_rd_req_o` is 1 in the same cycle for every load that is not forwarded. This includes loads from the less speculative context and loads while no window is open.
- R6: In thread mode, a store from the less speculative context (`req_older_i`=1) to an address the owning context loaded from memory pulses `violation_o` and `restart_o` in the next cycle. It empties the buffer and the read set, and the window stays open.
- R7: A store from the less speculative context raises no violation when the address was never loaded from memory by the owning context. This includes addresses the owning context only read through forwarding.
- R8: In transaction mode (`mode_txn_i`=1 at start), stores from the less speculative context never raise a violation.
- R9: An abort in transaction mode pulses `redirect_o` and `ckpt_restore_o` in the next cycle, with `redirect_pc_o` equal to the handler address latched at start. `restart_o` stays 0.
- R10: `full_o` is 1 while a window is open and the buffer holds DEPTH stores, or (thread mode only) the read set holds RSET_DEPTH addresses. With policy 0 the block then commits in that cycle.
- R11: With policy 1 (`policy_abort_i`=1 at start), a full condition aborts the window in that cycle. A store offered in that cycle is dropped.
- R12: When commit and abort are requested in the same cycle, the abort wins. An abort or commit in the cycle of a violating store takes precedence over the violation.
- R13: While no window is open, stores from the owning context are ignored, and `start_i` is ignored while a drain is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Open a window (accepted only when idle and not draining) |
| mode_txn_i | input | 1 | 0 thread speculation, 1 transaction; latched at start |
| policy_abort_i | input | 1 | Full policy: 0 commit, 1 abort; latched at start |
| handler_pc_i | input | AW | Handler address, latched at start |
| req_valid_i | input | 1 | Memory request valid |
| req_write_i | input | 1 | 1 store, 0 load |
| req_older_i | input | 1 | 1 request from the less speculative context |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Store data |
| commit_i | input | 1 | Commit the window |
| abort_i | input | 1 | Abort the window |
| fwd_hit_o | output | 1 | Load served from the buffer |
| fwd_data_o | output | DW | Forwarded load data |
| mem_rd_req_o | output | 1 | Load must be served by memory |
| drain_valid_o | output | 1 | Drain port carries a store |
| drain_addr_o | output | AW | Drained store address |
| drain_data_o | output | DW | Drained store data |
| drain_busy_o | output | 1 | Committed stores still pending |
| full_o | output | 1 | Buffer or read set full |
| violation_o | output | 1 | Dependence violation pulse |
| restart_o | output | 1 | Thread re-execution request pulse |
| redirect_o | output | 1 | Jump-to-handler pulse |
| redirect_pc_o | output | AW | Handler address |
| ckpt_restore_o | output | 1 | Register checkpoint restore pulse |

## Verification
The hardest situation to reach is a violating store that must be told apart from a harmless one. The owning context has to load an address from memory first. Then the less speculative context writes the same address, while other addresses were only read through forwarding or never read. The stimulus builds such windows step by step: a store, a forwarded load of it, a memory load of another address, then writes from the less speculative context to each. It also repeats the sequence in transaction mode, where the same write must stay silent. The full-policy paths are reached with a small buffer and read-set depth, so that a handful of stores or loads fills them.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

  typedef enum logic {
    MODE_THREAD = 1'b0,
    MODE_TXN    = 1'b1
  } ssb_mode_e;

  // Full when the store queue is at capacity, or, in thread mode, the read set is.
  function automatic logic ssb_is_full(input logic active, input logic txn,
                                       input int st_cnt, input int st_depth,
                                       input int rd_cnt, input int rd_depth);
    return active && ((st_cnt == st_depth) || (!txn && (rd_cnt == rd_depth)));
  endfunction

endpackage

// File: rtl/ssb_store_array.sv
module ssb_store_array #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          clear,
  input  logic          drain_go,
  input  logic          lk_en,
  input  logic [AW-1:0] lk_addr,
  output logic [CW-1:0] count,
  output logic          hit,
  output logic [DW-1:0] hit_data,
  output logic          draining,
  output logic [AW-1:0] drain_addr,
  output logic [DW-1:0] drain_data
);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] dptr_q;
  logic          draining_q;
  logic          last_drain;

  assign count      = cnt_q;
  assign draining   = draining_q;
  assign drain_addr = addr_q[dptr_q];
  assign drain_data = data_q[dptr_q];
  assign last_drain = draining_q && (CW'(dptr_q) == cnt_q - CW'(1));

  // Youngest match wins: later indices overwrite earlier ones.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lk_en && (CW'(i) < cnt_q) && (addr_q[i] == lk_addr)) begin
        hit      = 1'b1;
        hit_data = data_q[i];
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        data_q[g] <= '0;
      end else if (wr_en && (PW'(cnt_q) == PW'(g))) begin
        addr_q[g] <= wr_addr;
        data_q[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      dptr_q     <= '0;
      draining_q <= 1'b0;
    end else if (clear) begin
      cnt_q      <= '0;
      draining_q <= 1'b0;
      dptr_q     <= '0;
    end else if (drain_go) begin
      draining_q <= 1'b1;
      dptr_q     <= '0;
    end else if (last_drain) begin
      draining_q <= 1'b0;
      cnt_q      <= '0;
      dptr_q     <= '0;
    end else if (draining_q) begin
      dptr_q <= dptr_q + PW'(1);
    end else if (wr_en) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R2: one store per cycle, in order, until the last one.
  assert_drain_in_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (draining_q && !last_drain && !clear) |=> (draining_q && dptr_q == $past(dptr_q) + PW'(1)));

  assert_drain_ends_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (last_drain && !clear) |=> (!draining_q && cnt_q == '0));

endmodule

// File: rtl/ssb_read_set.sv
module ssb_read_set #(
  parameter int RDEPTH = 8,
  parameter int AW     = 32,
  localparam int RCW   = $clog2(RDEPTH + 1),
  localparam int RPW   = (RDEPTH > 1) ? $clog2(RDEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rec_en,
  input  logic           clear,
  input  logic [AW-1:0]  addr,
  output logic           seen,
  output logic [RCW-1:0] count
);

  logic [AW-1:0]  rs_q [RDEPTH];
  logic [RCW-1:0] rcnt_q;

  assign count = rcnt_q;

  always_comb begin
    seen = 1'b0;
    for (int i = 0; i < RDEPTH; i++) begin
      if ((RCW'(i) < rcnt_q) && (rs_q[i] == addr)) seen = 1'b1;
    end
  end

  for (genvar g = 0; g < RDEPTH; g++) begin : g_rs
    always_ff @(posedge clk) begin
      if (!rst_n) rs_q[g] <= '0;
      else if (rec_en && !clear && (RPW'(rcnt_q) == RPW'(g))) rs_q[g] <= addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rcnt_q <= '0;
    else if (clear)  rcnt_q <= '0;
    else if (rec_en) rcnt_q <= rcnt_q + RCW'(1);
  end

  // R6: the read set is never written past its capacity.
  assert_rset_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_en |-> (rcnt_q < RCW'(RDEPTH)));

endmodule

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_txn_i,
  input  logic          policy_abort_i,
  input  logic [AW-1:0] handler_pc_i,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          req_older_i,
  input  logic          commit_i,
  input  logic          abort_i,
  input  logic          full,
  input  logic          fwd_hit,
  input  logic          rset_seen,
  input  logic          rset_full,
  input  logic          buf_nonempty,
  input  logic          draining,
  output logic          active,
  output logic          txn_mode,
  output logic          own_ld,
  output logic          wr_en,
  output logic          rec_en,
  output logic          buf_clear,
  output logic          rset_clear,
  output logic          drain_go,
  output logic          abort_evt,
  output logic          commit_evt,
  output logic          viol_evt,
  output logic          violation_o,
  output logic          restart_o,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o,
  output logic          ckpt_restore_o
);

  logic      active_q, policy_q;
  ssb_mode_e mode_q;
  logic [AW-1:0] pc_q;
  logic own_st, older_st, hazard, start_evt, quiet;
  logic viol_q, restart_q, redirect_q, restore_q;

  assign active        = active_q;
  assign txn_mode      = (mode_q == MODE_TXN);
  assign redirect_pc_o = pc_q;
  assign violation_o   = viol_q;
  assign restart_o     = restart_q;
  assign redirect_o    = redirect_q;
  assign ckpt_restore_o = restore_q;

  always_comb begin
    own_ld     = active_q && req_valid_i && !req_older_i && !req_write_i;
    own_st     = active_q && req_valid_i && !req_older_i &&  req_write_i;
    older_st   = req_valid_i && req_write_i && req_older_i;
    abort_evt  = active_q && (abort_i || (full && policy_q));
    commit_evt = active_q && !abort_evt && (commit_i || (full && !policy_q));
    hazard     = active_q && (mode_q == MODE_THREAD) && older_st && rset_seen;
    viol_evt   = hazard && !abort_evt && !commit_evt;
    start_evt  = !active_q && !draining && start_i;
    quiet      = !abort_evt && !commit_evt && !viol_evt;
    wr_en      = quiet && own_st && !full;
    rec_en     = quiet && own_ld && !fwd_hit && (mode_q == MODE_THREAD)
                 && !rset_seen && !rset_full;
    buf_clear  = abort_evt || viol_evt;
    rset_clear = abort_evt || commit_evt || viol_evt;
    drain_go   = commit_evt && buf_nonempty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      policy_q   <= 1'b0;
      mode_q     <= MODE_THREAD;
      pc_q       <= '0;
      viol_q     <= 1'b0;
      restart_q  <= 1'b0;
      redirect_q <= 1'b0;
      restore_q  <= 1'b0;
    end else begin
      viol_q     <= viol_evt;
      restart_q  <= viol_evt || (abort_evt && mode_q == MODE_THREAD);
      redirect_q <= abort_evt && (mode_q == MODE_TXN);
      restore_q  <= abort_evt && (mode_q == MODE_TXN);
      if (start_evt) begin
        active_q <= 1'b1;
        mode_q   <= mode_txn_i ? MODE_TXN : MODE_THREAD;
        policy_q <= policy_abort_i;
        pc_q     <= handler_pc_i;
      end else if (abort_evt || commit_evt) begin
        active_q <= 1'b0;
      end
    end
  end

  // R8: a transaction window never reports a dependence violation.
  assert_txn_no_violation_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && mode_q == MODE_TXN) |=> !viol_q);

  // R9: a redirect always comes with a checkpoint restore and never with a restart.
  assert_redirect_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_q |-> (restore_q && !restart_q));

endmodule

// File: rtl/spec_store_buffer.sv
module spec_store_buffer
  import ssb_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int RSET_DEPTH  = 8,
  parameter int AW          = 32,
  parameter int DW          = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_txn_i,
  input  logic          policy_abort_i,
  input  logic [AW-1:0] handler_pc_i,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          req_older_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          commit_i,
  input  logic          abort_i,
  output logic          fwd_hit_o,
  output logic [DW-1:0] fwd_data_o,
  output logic          mem_rd_req_o,
  output logic          drain_valid_o,
  output logic [AW-1:0] drain_addr_o,
  output logic [DW-1:0] drain_data_o,
  output logic          drain_busy_o,
  output logic          full_o,
  output logic          violation_o,
  output logic          restart_o,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o,
  output logic          ckpt_restore_o
);

  localparam int CW  = $clog2(DEPTH + 1);
  localparam int RCW = $clog2(RSET_DEPTH + 1);

  logic [CW-1:0]  buf_count;
  logic [RCW-1:0] rset_count;
  logic active, txn_mode, own_ld, wr_en, rec_en, buf_clear, rset_clear, drain_go;
  logic abort_evt, commit_evt, viol_evt;
  logic fwd_hit, rset_seen, rset_full, draining, full;

  assign full      = ssb_is_full(active, txn_mode, int'(buf_count), DEPTH,
                                 int'(rset_count), RSET_DEPTH);
  assign rset_full = (rset_count == RCW'(RSET_DEPTH));

  ssb_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_txn_i(mode_txn_i),
    .policy_abort_i(policy_abort_i), .handler_pc_i(handler_pc_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_older_i(req_older_i),
    .commit_i(commit_i), .abort_i(abort_i), .full(full), .fwd_hit(fwd_hit),
    .rset_seen(rset_seen), .rset_full(rset_full), .buf_nonempty(buf_count != '0),
    .draining(draining), .active(active), .txn_mode(txn_mode), .own_ld(own_ld),
    .wr_en(wr_en), .rec_en(rec_en), .buf_clear(buf_clear), .rset_clear(rset_clear),
    .drain_go(drain_go), .abort_evt(abort_evt), .commit_evt(commit_evt),
    .viol_evt(viol_evt), .violation_o(violation_o), .restart_o(restart_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .ckpt_restore_o(ckpt_restore_o)
  );

  ssb_store_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(req_addr_i),
    .wr_data(req_wdata_i), .clear(buf_clear), .drain_go(drain_go),
    .lk_en(own_ld), .lk_addr(req_addr_i), .count(buf_count), .hit(fwd_hit),
    .hit_data(fwd_data_o), .draining(draining), .drain_addr(drain_addr_o),
    .drain_data(drain_data_o)
  );

  ssb_read_set #(.RDEPTH(RSET_DEPTH), .AW(AW)) u_rset (
    .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .clear(rset_clear),
    .addr(req_addr_i), .seen(rset_seen), .count(rset_count)
  );

  assign fwd_hit_o     = fwd_hit;
  assign mem_rd_req_o  = req_valid_i && !req_write_i && !fwd_hit;
  assign drain_valid_o = draining;
  assign drain_busy_o  = draining;
  assign full_o        = full;

  // R1: nothing leaves toward memory while the window is open.
  assert_no_drain_while_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !drain_valid_o);

  // R3: an abort leaves an empty buffer and no drain.
  assert_abort_discards_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (buf_count == '0 && !drain_busy_o));

  // R6: every violation comes with a restart request.
  assert_violation_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    violation_o |-> restart_o);

  // R6: after a violation the read set and buffer are empty.
  assert_violation_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    viol_evt |=> (buf_count == '0 && rset_count == '0));

endmodule

// File: tb/tb_spec_store_buffer.sv
module tb_spec_store_buffer;
  localparam int D  = 4;
  localparam int R  = 4;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, mtxn = 0, pol = 0, rv = 0, rw = 0, ro = 0, cmt = 0, abt = 0;
  logic [AW-1:0] hpc = '0, ra = '0;
  logic [DW-1:0] rd = '0;
  logic fwd_hit, mem_rd, dv, dbusy, full, viol, rst_o, redir, restore;
  logic [DW-1:0] fdata, ddata;
  logic [AW-1:0] daddr, rpc;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R13";

  // reference state
  bit m_act, m_txn, m_pol, m_drain, m_viol, m_rst, m_red;
  logic [AW-1:0] m_pc;
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];
  logic [AW-1:0] qr[$];

  always #4 clk = ~clk;

  spec_store_buffer #(.DEPTH(D), .RSET_DEPTH(R), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_txn_i(mtxn),
    .policy_abort_i(pol), .handler_pc_i(hpc), .req_valid_i(rv), .req_write_i(rw),
    .req_older_i(ro), .req_addr_i(ra), .req_wdata_i(rd), .commit_i(cmt),
    .abort_i(abt), .fwd_hit_o(fwd_hit), .fwd_data_o(fdata), .mem_rd_req_o(mem_rd),
    .drain_valid_o(dv), .drain_addr_o(daddr), .drain_data_o(ddata),
    .drain_busy_o(dbusy), .full_o(full), .violation_o(viol), .restart_o(rst_o),
    .redirect_o(redir), .redirect_pc_o(rpc), .ckpt_restore_o(restore)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc == 20000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  function automatic bit in_rset(input logic [AW-1:0] a);
    foreach (qr[i]) if (qr[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit m_full();
    return m_act && (qa.size() == D || (!m_txn && qr.size() == R));
  endfunction

  task automatic lookup(output bit h, output logic [DW-1:0] d);
    h = 0; d = '0;
    if (m_act && rv && !rw && !ro)
      foreach (qa[i]) if (qa[i] == ra) begin h = 1; d = qd[i]; end
  endtask

  task automatic compare();
    bit h; logic [DW-1:0] d;
    lookup(h, d);
    chk("full", full, m_full());
    chk("fwd_hit", fwd_hit, h);
    if (h) chk("fwd_data", fdata, d);
    chk("mem_rd_req", mem_rd, rv && !rw && !h);
    chk("drain_valid", dv, m_drain);
    chk("drain_busy", dbusy, m_drain);
    if (m_drain) begin
      chk("drain_addr", daddr, qa[0]);
      chk("drain_data", ddata, qd[0]);
    end
    chk("violation", viol, m_viol);
    chk("restart", rst_o, m_rst);
    chk("redirect", redir, m_red);
    chk("ckpt_restore", restore, m_red);
    if (m_red) chk("redirect_pc", rpc, m_pc);
  endtask

  task automatic model_edge();
    bit h, fl, ab, cm, vi, st;
    logic [DW-1:0] d;
    lookup(h, d);
    fl = m_full();
    ab = m_act && (abt || (fl && m_pol));
    cm = m_act && !ab && (cmt || (fl && !m_pol));
    vi = m_act && !m_txn && rv && rw && ro && in_rset(ra) && !ab && !cm;
    st = !m_act && !m_drain && start;
    m_viol = 0; m_rst = 0; m_red = 0;
    if (m_drain) begin
      void'(qa.pop_front()); void'(qd.pop_front());
      if (qa.size() == 0) m_drain = 0;
    end
    if (st) begin
      m_act = 1; m_txn = mtxn; m_pol = pol; m_pc = hpc;
    end else if (ab) begin
      m_act = 0; qa.delete(); qd.delete(); qr.delete();
      if (m_txn) m_red = 1; else m_rst = 1;
    end else if (cm) begin
      m_act = 0; qr.delete();
      if (qa.size() > 0) m_drain = 1;
    end else if (vi) begin
      qa.delete(); qd.delete(); qr.delete(); m_viol = 1; m_rst = 1;
    end else if (m_act && rv && rw && !ro && !fl) begin
      qa.push_back(ra); qd.push_back(rd);
    end else if (m_act && rv && !rw && !ro && !h && !m_txn && !in_rset(ra) && qr.size() < R) begin
      qr.push_back(ra);
    end
  endtask

  task automatic step();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    start = 0; rv = 0; rw = 0; ro = 0; cmt = 0; abt = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic go(input bit t, input bit p, input logic [AW-1:0] pc);
    start = 1; mtxn = t; pol = p; hpc = pc; step();
  endtask
  task automatic st_own(input logic [AW-1:0] a, input logic [DW-1:0] v);
    rv = 1; rw = 1; ro = 0; ra = a; rd = v; step();
  endtask
  task automatic ld_own(input logic [AW-1:0] a);
    rv = 1; rw = 0; ro = 0; ra = a; step();
  endtask
  task automatic st_old(input logic [AW-1:0] a, input logic [DW-1:0] v);
    rv = 1; rw = 1; ro = 1; ra = a; rd = v; step();
  endtask

  initial begin
    m_act = 0; m_txn = 0; m_pol = 0; m_drain = 0; m_viol = 0; m_rst = 0; m_red = 0;
    m_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state and idle requests
    cur_req = "R13"; idle(1);
    st_own(16'h10, 16'h1); ld_own(16'h10);
    // R1 / R4 / R5 / R2
    cur_req = "R1"; go(0, 0, 16'h0);
    st_own(16'h20, 16'hA); st_own(16'h24, 16'hB); st_own(16'h20, 16'hC);
    cur_req = "R4"; ld_own(16'h20); ld_own(16'h24);
    cur_req = "R5"; ld_own(16'h28); rv = 1; rw = 0; ro = 1; ra = 16'h20; step();
    cur_req = "R2"; cmt = 1; step();
    cur_req = "R13"; go(1, 0, 16'h55);   // ignored during drain
    cur_req = "R2"; idle(3);
    cur_req = "R2"; go(0, 0, 16'h0); cmt = 1; step(); idle(2);
    // R3 abort in thread mode
    cur_req = "R3"; go(0, 0, 16'h0); st_own(16'h30, 16'h3); st_own(16'h34, 16'h4);
    abt = 1; step(); idle(3);
    // R6 violation
    cur_req = "R6"; go(0, 0, 16'h0); st_own(16'h40, 16'h7); ld_own(16'h44);
    st_old(16'h44, 16'h9); idle(1); ld_own(16'h40); cmt = 1; step(); idle(2);
    // R7 no violation
    cur_req = "R7"; go(0, 0, 16'h0); st_own(16'h50, 16'h5); ld_own(16'h50);
    st_old(16'h50, 16'h6); st_old(16'h58, 16'h6); ld_own(16'h5C); st_old(16'h60, 16'h1);
    cmt = 1; step(); idle(2);
    // R8 / R9 transaction
    cur_req = "R8"; go(1, 0, 16'hBEEF); ld_own(16'h70); st_own(16'h74, 16'h2);
    st_old(16'h70, 16'h3); idle(1);
    cur_req = "R9"; abt = 1; step(); idle(2);
    // R10 commit by default on full
    cur_req = "R10"; go(0, 0, 16'h0);
    for (int i = 0; i < D; i++) st_own(16'h80 + 16'(i), 16'h100 + 16'(i));
    st_own(16'h90, 16'hFF); idle(D + 1);
    // R11 abort by default: stores in txn, loads in thread mode
    cur_req = "R11"; go(1, 1, 16'h1234);
    for (int i = 0; i < D; i++) st_own(16'hA0 + 16'(i), 16'h200 + 16'(i));
    st_own(16'hB0, 16'hEE); idle(2);
    go(0, 1, 16'h0);
    for (int i = 0; i < R; i++) ld_own(16'hC0 + 16'(i));
    idle(2);
    // R12 priority
    cur_req = "R12"; go(0, 0, 16'h0); st_own(16'hD0, 16'h1); cmt = 1; abt = 1; step(); idle(2);
    go(0, 0, 16'h0); ld_own(16'hD4); rv = 1; rw = 1; ro = 1; ra = 16'hD4; cmt = 1; step();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule